// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block decides which interrupt a processor core takes next. Requests arrive one per cycle as a vector number, a three-bit delivery mode and a level/edge flag. Ordinary requests (fixed and lowest-priority) are collected in a request bit array with one bit per vector. The block compares the highest requested vector against the highest vector already in service and against the class held in a task priority register. Special requests (system management, non-maskable, init, startup and external) bypass those arrays. Each one sits in a single-entry slot with its own stored vector.

Every cycle the block presents a single candidate to the core: a deliverable flag, a delivery mode and a vector. The core's interrupt-enable flag is an input. It gates the external slot and the ordinary vectors, but not the four unmaskable kinds. When the core accepts the candidate it pulses `ack`, and the block retires that slot or moves the vector from request to in-service. An end-of-interrupt strobe later releases the highest in-service vector. A probe port reads back the request, in-service and trigger-mode bits of any one vector.

Top module: `vec_irq_arbiter`

## Requirements
- R1: After reset, no request, in-service or trigger bit is set, no slot is pending, `deliver_valid` is low, `tpr_value` is 0 and `core_started` is low.
- R2: A request with mode 0 (fixed) or mode 1 (lowest-priority) sets the vector's request bit. Only if that bit was clear beforehand is the vector's trigger bit written: to 1 when `req_level` is high, to 0 when it is low.
- R3: Mode 2 (system management), 4 (non-maskable), 5 (init) and 7 (external) each own one slot, which holds a pending flag and a vector. A request for a slot that is already pending is dropped, and the first vector is kept. Mode 3 is reserved, and a request with mode 3 changes nothing.
- R4: A mode 6 (startup) request is accepted only when no startup is pending and `core_started` is low. Acknowledging an init clears `core_started`, and acknowledging a startup sets it.
- R5: A pending unmaskable slot makes `deliver_valid` high whatever `intr_en` is. The slot chosen is the first pending one in the order system management, non-maskable, init, startup. It is presented with its mode code (2, 4, 5, 6) and its stored vector.
- R6: When `intr_en` is high and no unmaskable slot is pending, a pending external slot is presented next, with mode 7.
- R7: Otherwise, when `intr_en` is high, the highest requested vector is presented with mode 0. This happens only if that vector is greater than the highest in-service vector, and its bits 7:4 are greater than bits 7:4 of the task priority. An empty array counts as vector 0.
- R8: An accepted ordinary delivery clears the vector's request bit and sets its in-service bit, one cycle after `ack`.
- R9: `eoi_wr` clears the in-service bit of the highest in-service vector.
- R10: A `tpr_wr` stores only bits 7:0 of `tpr_wdata`, and the stored value appears on `tpr_value` the next cycle.
- R11: `ack` while `deliver_valid` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered this cycle |
| req_vector | input | VEC_W | Vector number of the request |
| req_mode | input | 3 | Delivery mode code of the request |
| req_level | input | 1 | 1 for level-triggered, 0 for edge-triggered |
| intr_en | input | 1 | Core's interrupt-enable flag |
| tpr_wr | input | 1 | Write strobe of the task priority register |
| tpr_wdata | input | DATA_W | Write data for the task priority register |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| ack | input | 1 | Core accepts the presented interrupt |
| probe_vec | input | VEC_W | Vector whose bits are read on the probe outputs |
| deliver_valid | output | 1 | An interrupt is deliverable |
| deliver_mode | output | 3 | Mode code of the presented interrupt |
| deliver_vector | output | VEC_W | Vector of the presented interrupt |
| tpr_value | output | VEC_W | Current task priority |
| core_started | output | 1 | The core has taken a startup since its last init |
| probe_req | output | 1 | Request bit of `probe_vec` |
| probe_isr | output | 1 | In-service bit of `probe_vec` |
| probe_trig | output | 1 | Trigger-mode bit of `probe_vec` |

## Verification
The assertions check on every cycle that a masked core is only ever offered an unmaskable kind, and that a pending system-management slot always wins the output. They also check that an ordinary vector on the output clears the task priority class, that an accepted ordinary vector becomes the highest in-service vector, and that an end-of-interrupt lowers it. Several behaviours need a history of stimulus and can only be shown by the bench scenarios. These are dropped duplicate and reserved requests, a trigger bit that stays put on a repeated request, startup refusal after an earlier start, and an ack that has no effect when nothing is deliverable. Random mixed traffic is then compared against a bench model of the arrays and slots.

// File: rtl/virq_pkg.sv
package virq_pkg;
   // delivery mode codes
   localparam logic [2:0] DM_FIXED  = 3'd0;
   localparam logic [2:0] DM_LOWEST = 3'd1;
   localparam logic [2:0] DM_SMI    = 3'd2;
   localparam logic [2:0] DM_RSVD   = 3'd3;
   localparam logic [2:0] DM_NMI    = 3'd4;
   localparam logic [2:0] DM_INIT   = 3'd5;
   localparam logic [2:0] DM_START  = 3'd6;
   localparam logic [2:0] DM_EXT    = 3'd7;

   // slot indices; lower index wins among unmaskable slots
   localparam int NSLOT    = 5;
   localparam int SL_SMI   = 0;
   localparam int SL_NMI   = 1;
   localparam int SL_INIT  = 2;
   localparam int SL_START = 3;
   localparam int SL_EXT   = 4;
   localparam logic [2:0] SL_NONE = 3'd7;

   function automatic logic [2:0] slot_of(input logic [2:0] mode);
      case (mode)
         DM_SMI:   return 3'(SL_SMI);
         DM_NMI:   return 3'(SL_NMI);
         DM_INIT:  return 3'(SL_INIT);
         DM_START: return 3'(SL_START);
         DM_EXT:   return 3'(SL_EXT);
         default:  return SL_NONE;
      endcase
   endfunction

   function automatic logic [2:0] mode_of(input logic [2:0] slot);
      case (slot)
         3'(SL_SMI):   return DM_SMI;
         3'(SL_NMI):   return DM_NMI;
         3'(SL_INIT):  return DM_INIT;
         3'(SL_START): return DM_START;
         default:      return DM_EXT;
      endcase
   endfunction
endpackage

// File: rtl/virq_prio_enc.sv
module virq_prio_enc #(
   parameter int N = 256,
   parameter int W = 8
) (
   input  logic [N-1:0] bits_in,
   output logic [W-1:0] top_idx,
   output logic         any_set
);
   always_comb begin
      top_idx = '0;
      any_set = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (bits_in[i]) begin
            top_idx = W'(i);
            any_set = 1'b1;
         end
      end
   end
endmodule

// File: rtl/virq_vec_store.sv
module virq_vec_store #(
   parameter int VEC_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [VEC_W-1:0]     set_vec,
   input  logic                 set_level,
   input  logic                 move_en,
   input  logic [VEC_W-1:0]     move_vec,
   input  logic                 retire_en,
   input  logic [VEC_W-1:0]     retire_vec,
   input  logic [VEC_W-1:0]     probe_vec,
   output logic [(1<<VEC_W)-1:0] req_bits,
   output logic [(1<<VEC_W)-1:0] isr_bits,
   output logic                 probe_trig
);
   localparam int NVEC = 1 << VEC_W;
   localparam logic [NVEC-1:0] ONE = {{(NVEC-1){1'b0}}, 1'b1};

   logic [NVEC-1:0] req_q, isr_q, trg_q;
   logic [NVEC-1:0] set_mask, move_mask, retire_mask;

   assign set_mask    = set_en    ? (ONE << set_vec)    : '0;
   assign move_mask   = move_en   ? (ONE << move_vec)   : '0;
   assign retire_mask = retire_en ? (ONE << retire_vec) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         isr_q <= '0;
         trg_q <= '0;
      end else begin
         req_q <= (req_q & ~move_mask) | set_mask;
         isr_q <= (isr_q & ~retire_mask) | move_mask;
         if (set_en && !req_q[set_vec])
            trg_q[set_vec] <= set_level;
      end
   end

   assign req_bits   = req_q;
   assign isr_bits   = isr_q;
   assign probe_trig = trg_q[probe_vec];
endmodule

// File: rtl/virq_slots.sv
module virq_slots
   import virq_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [2:0]                  in_mode,
   input  logic [VEC_W-1:0]            in_vec,
   input  logic                        take_en,
   input  logic [2:0]                  take_slot,
   output logic [NSLOT-1:0]            pend,
   output logic [NSLOT-1:0][VEC_W-1:0] vecs,
   output logic                        started
);
   logic [2:0] in_slot;
   assign in_slot = slot_of(in_mode);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic             p_q;
      logic [VEC_W-1:0] v_q;
      logic             acc, clr;
      if (s == SL_START) begin : g_gated
         assign acc = in_valid && (in_slot == 3'(s)) && !p_q && !started;
      end else begin : g_plain
         assign acc = in_valid && (in_slot == 3'(s)) && !p_q;
      end
      assign clr = take_en && (take_slot == 3'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= 1'b0;
            v_q <= '0;
         end else begin
            p_q <= (p_q && !clr) || acc;
            if (acc) v_q <= in_vec;
         end
      end
      assign pend[s] = p_q;
      assign vecs[s] = v_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         started <= 1'b0;
      else if (take_en && take_slot == 3'(SL_INIT))
         started <= 1'b0;
      else if (take_en && take_slot == 3'(SL_START))
         started <= 1'b1;
   end
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
   import virq_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VEC_W-1:0]  req_vector,
   input  logic [2:0]        req_mode,
   input  logic              req_level,
   input  logic              intr_en,
   input  logic              tpr_wr,
   input  logic [DATA_W-1:0] tpr_wdata,
   input  logic              eoi_wr,
   input  logic              ack,
   input  logic [VEC_W-1:0]  probe_vec,
   output logic              deliver_valid,
   output logic [2:0]        deliver_mode,
   output logic [VEC_W-1:0]  deliver_vector,
   output logic [VEC_W-1:0]  tpr_value,
   output logic              core_started,
   output logic              probe_req,
   output logic              probe_isr,
   output logic              probe_trig
);
   localparam int NVEC  = 1 << VEC_W;
   localparam int CLS_W = 4;
   localparam int CLS_LO = VEC_W - CLS_W;

   if (VEC_W < CLS_W) begin : g_bad_vec
      $error("VEC_W must hold a priority class");
   end
   if (DATA_W < VEC_W) begin : g_bad_data
      $error("DATA_W must be at least VEC_W");
   end

   logic [NVEC-1:0]             req_bits, isr_bits;
   logic [VEC_W-1:0]            irrv, isrv;
   logic                        irr_any, isr_any;
   logic [NSLOT-1:0]            slot_pend;
   logic [NSLOT-1:0][VEC_W-1:0] slot_vecs;
   logic [VEC_W-1:0]            tpr_q;
   logic                        reg_ok, sel_reg, take;
   logic [2:0]                  sel_slot;
   logic                        std_req;

   assign std_req = req_valid && (req_mode == DM_FIXED || req_mode == DM_LOWEST);

   virq_prio_enc #(.N(NVEC), .W(VEC_W)) u_irr_enc (
      .bits_in(req_bits), .top_idx(irrv), .any_set(irr_any));
   virq_prio_enc #(.N(NVEC), .W(VEC_W)) u_isr_enc (
      .bits_in(isr_bits), .top_idx(isrv), .any_set(isr_any));

   virq_vec_store #(.VEC_W(VEC_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .set_en(std_req), .set_vec(req_vector), .set_level(req_level),
      .move_en(take && sel_reg), .move_vec(irrv),
      .retire_en(eoi_wr), .retire_vec(isrv),
      .probe_vec(probe_vec),
      .req_bits(req_bits), .isr_bits(isr_bits), .probe_trig(probe_trig));

   virq_slots #(.VEC_W(VEC_W)) u_slots (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_mode(req_mode), .in_vec(req_vector),
      .take_en(take && !sel_reg), .take_slot(sel_slot),
      .pend(slot_pend), .vecs(slot_vecs), .started(core_started));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tpr_q <= '0;
      else if (tpr_wr) tpr_q <= tpr_wdata[VEC_W-1:0];
   end

   assign reg_ok = irr_any && (irrv > isrv) &&
                   (irrv[VEC_W-1:CLS_LO] > tpr_q[VEC_W-1:CLS_LO]);

   always_comb begin
      deliver_valid  = 1'b0;
      deliver_mode   = DM_FIXED;
      deliver_vector = '0;
      sel_slot       = SL_NONE;
      sel_reg        = 1'b0;
      if (|slot_pend[SL_START:SL_SMI]) begin
         deliver_valid = 1'b1;
         for (int s = SL_START; s >= SL_SMI; s--) begin
            if (slot_pend[s]) begin
               sel_slot       = 3'(s);
               deliver_vector = slot_vecs[s];
            end
         end
         deliver_mode = mode_of(sel_slot);
      end else if (intr_en && slot_pend[SL_EXT]) begin
         deliver_valid  = 1'b1;
         sel_slot       = 3'(SL_EXT);
         deliver_mode   = DM_EXT;
         deliver_vector = slot_vecs[SL_EXT];
      end else if (intr_en && reg_ok) begin
         deliver_valid  = 1'b1;
         sel_reg        = 1'b1;
         deliver_vector = irrv;
      end
   end

   assign take      = ack && deliver_valid;
   assign tpr_value = tpr_q;
   assign probe_req = req_bits[probe_vec];
   assign probe_isr = isr_bits[probe_vec];
endmodule

// File: rtl/virq_checker.sv
module virq_checker #(
   parameter int VEC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             intr_en,
   input logic             ack,
   input logic             eoi_wr,
   input logic             deliver_valid,
   input logic [2:0]       deliver_mode,
   input logic [VEC_W-1:0] deliver_vector,
   input logic [VEC_W-1:0] tpr_value,
   input logic [4:0]       pend,
   input logic [VEC_W-1:0] isr_top
);
   // R5
   masked_only_unmaskable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver_valid && !intr_en) |->
         (deliver_mode == 3'd2 || deliver_mode == 3'd4 ||
          deliver_mode == 3'd5 || deliver_mode == 3'd6));

   // R5
   smi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[0] |-> (deliver_valid && deliver_mode == 3'd2));

   // R7
   class_above_tpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver_valid && deliver_mode == 3'd0) |->
         (deliver_vector[VEC_W-1:VEC_W-4] > tpr_value[VEC_W-1:VEC_W-4]));

   // R8
   ack_to_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && deliver_valid && deliver_mode == 3'd0) |=>
         (isr_top == $past(deliver_vector)));

   // R9
   eoi_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !(ack && deliver_valid) && isr_top != '0) |=>
         (isr_top < $past(isr_top)));
endmodule

bind vec_irq_arbiter virq_checker #(.VEC_W(VEC_W)) u_virq_chk (
   .clk(clk), .rst_n(rst_n), .intr_en(intr_en), .ack(ack), .eoi_wr(eoi_wr),
   .deliver_valid(deliver_valid), .deliver_mode(deliver_mode),
   .deliver_vector(deliver_vector), .tpr_value(tpr_value),
   .pend(slot_pend), .isr_top(isrv));

// File: tb/tb_vec_irq_arbiter.sv
module tb_vec_irq_arbiter;
   localparam int TCLK = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_level = 0, intr_en = 0, tpr_wr = 0, eoi_wr = 0, ack = 0;
   logic [7:0] req_vector = '0, probe_vec = '0;
   logic [2:0] req_mode = '0;
   logic [31:0] tpr_wdata = '0;
   logic deliver_valid, core_started, probe_req, probe_isr, probe_trig;
   logic [2:0] deliver_mode;
   logic [7:0] deliver_vector, tpr_value;

   vec_irq_arbiter dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
      .req_mode(req_mode), .req_level(req_level), .intr_en(intr_en),
      .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .eoi_wr(eoi_wr), .ack(ack),
      .probe_vec(probe_vec), .deliver_valid(deliver_valid),
      .deliver_mode(deliver_mode), .deliver_vector(deliver_vector),
      .tpr_value(tpr_value), .core_started(core_started),
      .probe_req(probe_req), .probe_isr(probe_isr), .probe_trig(probe_trig));

   always #(TCLK/2) clk = ~clk;

   // reference state
   bit [255:0] m_req, m_isr, m_trg;
   bit [4:0]   m_pend;
   int         m_vec [5];
   bit         m_started;
   int         m_tpr;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   function automatic int hi(input bit [255:0] b);
      int r = 0;
      for (int i = 0; i < 256; i++) if (b[i]) r = i;
      return r;
   endfunction

   function automatic int smode(input int s);
      case (s) 0: return 2; 1: return 4; 2: return 5; 3: return 6; default: return 7; endcase
   endfunction

   function automatic int slotof(input int m);
      case (m) 2: return 0; 4: return 1; 5: return 2; 6: return 3; 7: return 4; default: return 7; endcase
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic predict(input bit en, output bit v, output int m, output int vec,
                          output int slot, output bit isreg, output string tag);
      v = 0; m = 0; vec = 0; slot = 7; isreg = 0; tag = "R7";
      if (|m_pend[3:0]) begin
         v = 1; tag = "R5";
         for (int s = 3; s >= 0; s--) if (m_pend[s]) slot = s;
         m = smode(slot); vec = m_vec[slot];
      end else if (en && m_pend[4]) begin
         v = 1; tag = "R6"; slot = 4; m = 7; vec = m_vec[4];
      end else if (en && hi(m_req) > hi(m_isr) && (hi(m_req) / 16) > (m_tpr / 16)) begin
         v = 1; isreg = 1; vec = hi(m_req);
      end
   endtask

   // one cycle: drive after negedge, check, clock, update model
   task automatic cyc(input bit rv, input int mode, input int vec, input bit lvl,
                      input bit en, input bit tw, input bit [31:0] td,
                      input bit eoi, input bit ak, input int pv);
      bit v, isreg; int m, dvec, slot, ir, is, ss; string tag;
      bit [255:0] oreq; bit [4:0] opend; bit ost;
      req_valid = rv; req_mode = 3'(mode); req_vector = 8'(vec); req_level = lvl;
      intr_en = en; tpr_wr = tw; tpr_wdata = td; eoi_wr = eoi; ack = ak; probe_vec = 8'(pv);
      #1;
      predict(en, v, m, dvec, slot, isreg, tag);
      chk(tag, "deliver_valid", int'(deliver_valid), int'(v));
      if (v) begin
         chk(tag, "deliver_mode", int'(deliver_mode), m);
         chk(tag, "deliver_vector", int'(deliver_vector), dvec);
      end
      chk("R2", "probe_req", int'(probe_req), int'(m_req[pv]));
      chk("R2", "probe_trig", int'(probe_trig), int'(m_trg[pv]));
      chk("R8 R9", "probe_isr", int'(probe_isr), int'(m_isr[pv]));
      chk("R10", "tpr_value", int'(tpr_value), m_tpr);
      chk("R4", "core_started", int'(core_started), int'(m_started));
      @(posedge clk);
      oreq = m_req; opend = m_pend; ost = m_started;
      ir = hi(m_req); is = hi(m_isr);
      if (ak && v && isreg) m_req[ir] = 0;
      if (rv && (mode == 0 || mode == 1)) begin
         if (!oreq[vec]) m_trg[vec] = lvl;
         m_req[vec] = 1;
      end
      if (eoi) m_isr[is] = 0;
      if (ak && v && isreg) m_isr[ir] = 1;
      ss = slotof(mode);
      if (rv && ss != 7 && !opend[ss] && !(ss == 3 && ost)) begin
         m_pend[ss] = 1; m_vec[ss] = vec;
      end
      if (ak && v && !isreg) begin
         m_pend[slot] = 0;
         if (slot == 2) m_started = 0;
         if (slot == 3) m_started = 1;
      end
      if (tw) m_tpr = int'(td[7:0]);
      @(negedge clk);
   endtask

   task automatic idle(input bit en, input int pv);
      cyc(0, 0, 0, 0, en, 0, 0, 0, 0, pv);
   endtask

   initial begin
      #(TCLK * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int seed_junk;
      seed_junk = int'($urandom(32'd777));
      m_req = '0; m_isr = '0; m_trg = '0; m_pend = '0; m_started = 0; m_tpr = 0;
      for (int i = 0; i < 5; i++) m_vec[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R1", "deliver_valid", int'(deliver_valid), 0);
      chk("R1", "tpr_value", int'(tpr_value), 0);
      chk("R1", "core_started", int'(core_started), 0);
      chk("R1", "probe_req", int'(probe_req), 0);
      @(negedge clk);

      // ordinary vector, level
      cyc(1, 0, 8'h45, 1, 1, 0, 0, 0, 0, 8'h45);
      idle(1, 8'h45);
      chk("R7", "vector 0x45 offered", int'(deliver_vector), 8'h45);
      chk("R2", "trigger level", int'(probe_trig), 1);
      cyc(0, 0, 0, 0, 1, 0, 0, 0, 1, 8'h45);           // ack
      chk("R8", "isr bit", int'(probe_isr), 1);
      chk("R8", "req bit", int'(probe_req), 0);
      cyc(1, 1, 8'h42, 0, 1, 0, 0, 0, 0, 8'h42);       // below in-service
      chk("R7", "blocked by in-service", int'(deliver_valid), 0);
      cyc(1, 0, 8'h50, 1, 1, 0, 0, 0, 0, 8'h50);
      cyc(1, 0, 8'h50, 0, 1, 0, 0, 0, 0, 8'h50);       // repeat edge
      chk("R2", "trigger kept", int'(probe_trig), 1);
      cyc(0, 0, 0, 0, 1, 1, 32'h0000_0060, 0, 0, 8'h50);
      chk("R7", "blocked by class", int'(deliver_valid), 0);
      cyc(0, 0, 0, 0, 1, 1, 32'hABCD_1234, 0, 0, 8'h50);
      chk("R10", "low byte kept", int'(tpr_value), 8'h34);
      chk("R7", "0x50 offered", int'(deliver_vector), 8'h50);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h50);           // ack while masked
      chk("R11", "req bit untouched", int'(probe_req), 1);
      idle(1, 8'h50);
      chk("R11", "still offered", int'(deliver_vector), 8'h50);
      cyc(0, 0, 0, 0, 1, 0, 0, 0, 1, 8'h50);
      cyc(0, 0, 0, 0, 1, 0, 0, 1, 0, 8'h50);           // eoi
      chk("R9", "0x50 retired", int'(probe_isr), 0);
      cyc(0, 0, 0, 0, 1, 0, 0, 1, 0, 8'h45);
      chk("R9", "0x45 retired", int'(probe_isr), 0);
      idle(1, 8'h42);
      chk("R7", "0x42 offered", int'(deliver_vector), 8'h42);

      // special slots, masked core
      cyc(1, 4, 8'h11, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 4, 8'h22, 0, 0, 0, 0, 0, 0, 0);
      chk("R3", "first nmi vector kept", int'(deliver_vector), 8'h11);
      cyc(1, 3, 8'h77, 0, 0, 0, 0, 0, 0, 8'h77);
      chk("R3", "reserved ignored", int'(deliver_vector), 8'h11);
      chk("R3", "reserved no request", int'(probe_req), 0);
      cyc(1, 2, 8'h01, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 5, 8'h03, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 6, 8'h04, 0, 0, 0, 0, 0, 0, 0);
      chk("R5", "smi first", int'(deliver_mode), 2);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      chk("R5", "nmi second", int'(deliver_mode), 4);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      chk("R5", "init third", int'(deliver_mode), 5);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      chk("R5", "startup fourth", int'(deliver_mode), 6);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      chk("R4", "started set", int'(core_started), 1);
      cyc(1, 6, 8'h09, 0, 0, 0, 0, 0, 0, 0);
      chk("R4", "startup refused", int'(deliver_valid), 0);
      cyc(1, 5, 8'h05, 0, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      chk("R4", "started cleared", int'(core_started), 0);
      cyc(1, 6, 8'h0A, 0, 0, 0, 0, 0, 0, 0);
      chk("R4", "startup accepted", int'(deliver_vector), 8'h0A);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      cyc(1, 7, 8'h30, 0, 0, 0, 0, 0, 0, 0);
      chk("R6", "ext masked", int'(deliver_valid), 0);
      idle(1, 0);
      chk("R6", "ext mode", int'(deliver_mode), 7);
      chk("R6", "ext vector", int'(deliver_vector), 8'h30);
      cyc(0, 0, 0, 0, 1, 0, 0, 0, 1, 0);

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         int md, r;
         r  = int'($urandom_range(0, 9));
         md = (r < 6) ? int'($urandom_range(0, 1)) : int'($urandom_range(0, 7));
         cyc($urandom_range(0, 1) == 1, md, int'($urandom_range(0, 255)),
             $urandom_range(0, 1) == 1, $urandom_range(0, 9) < 7,
             $urandom_range(0, 19) == 0, $urandom(), $urandom_range(0, 9) == 0,
             $urandom_range(0, 9) < 4, int'($urandom_range(0, 255)));
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule